// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block is a synchronous master for one external asynchronous static RAM of 8K x 8. A requester presents a read or write command with a single-cycle `req_i` while the block is idle. The block then drives the memory's address, its active-low chip select, write strobe and output enable, and its 8-bit data bus. The bus is split into output data, a driver enable and input data, so that the tri-state buffer sits at the pad. Each minimum interval of the memory is a parameter counted in clock cycles. The block stretches every phase to that count and keeps the address constant from the start of a cycle until it returns to idle.

A write places the address, then lowers chip select and write strobe together for the write-pulse length while it drives the data. It raises the write strobe first and chip select one cycle later, then holds both high for recovery. A read lowers chip select and output enable together for the access length and samples the bus on the last cycle of that interval. It then leaves the bus idle for a turnaround time before any later cycle. Each command ends with a one-cycle `done_o`. For a read, `rdata_o` is valid in that same cycle.

Top module: `sram_cyc_ctrl`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `busy_o`, `done_o` and `mem_dq_oe_o` are 0, and `mem_ce_no`, `mem_we_no` and `mem_oe_no` are 1.
- R2: A write accepted at a clock edge gives max(1,T_AS_CYC) cycles with all strobes high. It then gives max(T_WP_CYC,T_DS_CYC) cycles with `mem_ce_no`=0, `mem_we_no`=0 and `mem_dq_oe_o`=1, with `mem_dq_o` equal to the requested data throughout.
- R3: A write ends with `mem_we_no` rising while `mem_ce_no` stays low for one more cycle. `mem_dq_oe_o` is 1 only while `mem_we_no` is 0, and `mem_oe_no` is never low while `mem_we_no` is low.
- R4: After chip select rises at the end of a write, all strobes stay high for max(1, T_WR_CYC, T_WC_CYC - setup - pulse - 1) cycles before the block is idle again. With the defaults this is 11 cycles and the whole write lasts 38 cycles.
- R5: A read accepted at a clock edge gives the setup cycles of R2. It then gives max(T_RC_CYC,T_OE_CYC) cycles with `mem_ce_no`=0, `mem_oe_no`=0 and `mem_we_no`=1, and `mem_dq_oe_o`=0. `mem_dq_i` is sampled at the clock edge that ends this interval.
- R6: `done_o` is high for exactly one cycle per command. That cycle is the first one after chip select rises. For a read, `rdata_o` equals the sampled byte in that cycle.
- R7: After a read, all strobes stay high for max(1,T_TA_CYC) cycles before the block is idle. The next cycle can lower a strobe or enable the data drivers no earlier than that.
- R8: `req_i` is ignored while `busy_o` is 1. The address, data and kind of the running command do not change.
- R9: `mem_addr_o` holds the accepted address, unchanged, from the cycle after acceptance until the block is idle.
- R10: `busy_o` is 1 from the cycle after acceptance up to and including the last recovery or turnaround cycle, and 0 when idle. A command is accepted only at an edge where `busy_o` is 0 and `req_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Command request, taken when idle |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 13 | Command address |
| req_wdata_i | input | 8 | Write data |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Read data, valid with `done_o` after a read |
| mem_addr_o | output | 13 | Memory address |
| mem_ce_no | output | 1 | Memory chip select, active low |
| mem_we_no | output | 1 | Memory write strobe, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_dq_o | output | 8 | Data toward the memory |
| mem_dq_oe_o | output | 1 | Data driver enable at the pad |
| mem_dq_i | input | 8 | Data from the memory |

## Verification
The in-RTL assertions check several properties on every cycle:
- output enable and write strobe are never low together;
- the data drivers are never on while the write strobe is high;
- the write strobe always rises before chip select;
- `done_o` is a single pulse inside a busy period;
- the address stays unchanged while busy.

Other behaviours show only through the bench's scenarios. These are the exact phase lengths, the sampling point of read data against the memory's access time, and the turnaround before the bus is driven again. They also include the data stored and read back, and whether requests held high during a command are ignored. The bench's behavioural memory times each of these in clock cycles, and a per-cycle expected strobe schedule is compared on every clock.

// File: rtl/sram_cyc_pkg.sv
`timescale 1ns/1ps
package sram_cyc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WPULSE,
    ST_WEND,
    ST_RACC,
    ST_GAP
  } cyc_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
`timescale 1ns/1ps
module sram_cyc_timer #(
  parameter int CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          last_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);

endmodule

// File: rtl/sram_cyc_dpath.sv
`timescale 1ns/1ps
module sram_cyc_dpath #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          capture_i,
  input  logic [DW-1:0] dq_i,
  output logic          op_wr_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dq_o,
  output logic [DW-1:0] rdata_o
);

  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      wr_q    <= wr_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (capture_i) rdata_q <= dq_i;
  end

  assign op_wr_o = wr_q;
  assign addr_o  = addr_q;
  assign dq_o    = wdata_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/sram_cyc_fsm.sv
`timescale 1ns/1ps
module sram_cyc_fsm
  import sram_cyc_pkg::*;
#(
  parameter int AS_LEN = 1,
  parameter int WP_LEN = 25,
  parameter int WG_LEN = 11,
  parameter int RD_LEN = 38,
  parameter int TA_LEN = 9,
  parameter int CW     = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          op_wr_i,
  input  logic          last_i,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output logic          accept_o,
  output logic          capture_o,
  output logic          busy_o,
  output logic          ce_no,
  output logic          we_no,
  output logic          oe_no,
  output logic          drv_o,
  output logic          done_o
);

  cyc_state_e st_q, st_d;
  logic       fin;
  logic       ce_q, we_q, oe_q, drv_q, done_q;

  always_comb begin
    st_d       = st_q;
    load_o     = 1'b0;
    load_val_o = '0;
    accept_o   = 1'b0;
    capture_o  = 1'b0;
    fin        = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_i) begin
        st_d       = ST_SETUP;
        load_o     = 1'b1;
        load_val_o = CW'(AS_LEN - 1);
        accept_o   = 1'b1;
      end
      ST_SETUP: if (last_i) begin
        load_o = 1'b1;
        if (op_wr_i) begin
          st_d       = ST_WPULSE;
          load_val_o = CW'(WP_LEN - 1);
        end else begin
          st_d       = ST_RACC;
          load_val_o = CW'(RD_LEN - 1);
        end
      end
      ST_WPULSE: if (last_i) begin
        st_d   = ST_WEND;
        load_o = 1'b1;
      end
      ST_WEND: begin
        st_d       = ST_GAP;
        load_o     = 1'b1;
        load_val_o = CW'(WG_LEN - 1);
        fin        = 1'b1;
      end
      ST_RACC: if (last_i) begin
        st_d       = ST_GAP;
        load_o     = 1'b1;
        load_val_o = CW'(TA_LEN - 1);
        capture_o  = 1'b1;
        fin        = 1'b1;
      end
      ST_GAP: if (last_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // strobes registered from next state: glitch-free pads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ce_q   <= 1'b1;
      we_q   <= 1'b1;
      oe_q   <= 1'b1;
      drv_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ce_q   <= !(st_d inside {ST_WPULSE, ST_WEND, ST_RACC});
      we_q   <= (st_d != ST_WPULSE);
      oe_q   <= (st_d != ST_RACC);
      drv_q  <= (st_d == ST_WPULSE);
      done_q <= fin;
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign ce_no  = ce_q;
  assign we_no  = we_q;
  assign oe_no  = oe_q;
  assign drv_o  = drv_q;
  assign done_o = done_q;

  assert_oe_we_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!oe_q && !we_q));
  assert_drv_in_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_q |-> !we_q && !ce_q);
  assert_we_before_ce_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_q) |-> !ce_q);
  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_done_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> busy_o && ce_q);
  assert_read_strobes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_q) |-> we_q && !ce_q && !drv_q);

endmodule

// File: rtl/sram_cyc_ctrl.sv
`timescale 1ns/1ps
module sram_cyc_ctrl #(
  parameter int AW        = 13,
  parameter int DW        = 8,
  parameter int T_AS_CYC  = 1,
  parameter int T_WP_CYC  = 25,
  parameter int T_DS_CYC  = 15,
  parameter int T_WR_CYC  = 1,
  parameter int T_WC_CYC  = 38,
  parameter int T_RC_CYC  = 38,
  parameter int T_OE_CYC  = 18,
  parameter int T_TA_CYC  = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          req_wr_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_ce_no,
  output logic          mem_we_no,
  output logic          mem_oe_no,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);
  import sram_cyc_pkg::*;

  localparam int AS_LEN  = max2(T_AS_CYC, 1);
  localparam int WP_LEN  = max2(max2(T_WP_CYC, T_DS_CYC), 1);
  localparam int WG_LEN  = max2(max2(T_WR_CYC, T_WC_CYC - AS_LEN - WP_LEN - 1), 1);
  localparam int RD_LEN  = max2(max2(T_RC_CYC, T_OE_CYC), 1);
  localparam int TA_LEN  = max2(T_TA_CYC, 1);
  localparam int LONGEST = max2(max2(max2(AS_LEN, WP_LEN), max2(WG_LEN, RD_LEN)), TA_LEN);
  localparam int CW      = $clog2(LONGEST + 1);

  logic          load, last, accept, capture, op_wr;
  logic [CW-1:0] load_val;

  sram_cyc_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .val_i  (load_val),
    .last_o (last)
  );

  sram_cyc_fsm #(
    .AS_LEN (AS_LEN),
    .WP_LEN (WP_LEN),
    .WG_LEN (WG_LEN),
    .RD_LEN (RD_LEN),
    .TA_LEN (TA_LEN),
    .CW     (CW)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .op_wr_i    (op_wr),
    .last_i     (last),
    .load_o     (load),
    .load_val_o (load_val),
    .accept_o   (accept),
    .capture_o  (capture),
    .busy_o     (busy_o),
    .ce_no      (mem_ce_no),
    .we_no      (mem_we_no),
    .oe_no      (mem_oe_no),
    .drv_o      (mem_dq_oe_o),
    .done_o     (done_o)
  );

  sram_cyc_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .wr_i      (req_wr_i),
    .addr_i    (req_addr_i),
    .wdata_i   (req_wdata_i),
    .capture_i (capture),
    .dq_i      (mem_dq_i),
    .op_wr_o   (op_wr),
    .addr_o    (mem_addr_o),
    .dq_o      (mem_dq_o),
    .rdata_o   (rdata_o)
  );

  assert_addr_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(mem_addr_o));
  assert_req_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(mem_dq_o));

endmodule

// File: tb/tb_sram_cyc_ctrl.sv
`timescale 1ns/1ps
module tb_sram_cyc_ctrl;
  localparam int AW = 13;
  localparam int DW = 8;
  // expected timing in cycles at 4 ns
  localparam int SETUP_N = 1;
  localparam int PULSE_N = 25;
  localparam int WGAP_N  = 11;
  localparam int RACC_N  = 38;
  localparam int TURN_N  = 9;
  localparam int MIN_WP  = 25;   // 100 ns
  localparam int MIN_DS  = 15;   // 60 ns
  localparam int MIN_ACC = 38;   // 150 ns, covers 70 ns from OE
  localparam int REL_N   = 9;    // 35 ns bus release

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req = 1'b0, req_wr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          busy, done, ce_n, we_n, oe_n, dq_oe;
  logic [DW-1:0] rdata, dq_o;
  logic [DW-1:0] dq_i = '0;
  logic [AW-1:0] maddr;

  sram_cyc_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_wr_i(req_wr),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .busy_o(busy),
    .done_o(done), .rdata_o(rdata), .mem_addr_o(maddr), .mem_ce_no(ce_n),
    .mem_we_no(we_n), .mem_oe_no(oe_n), .mem_dq_o(dq_o),
    .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string tg, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tg, what, act, exp);
    end
  endtask

  function automatic string tagname(input int t);
    case (t)
      2: return "R2";  3: return "R3";  4: return "R4";  5: return "R5";
      6: return "R6";  7: return "R7";  default: return "R10";
    endcase
  endfunction

  function automatic logic [7:0] pattern(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  // reference model: {busy,ce_n,we_n,oe_n,dq_oe,done}
  localparam logic [5:0] V_IDLE = 6'b011100;
  logic [5:0]    exp_q[$];
  int            tag_q[$];
  logic [5:0]    cur_v = V_IDLE;
  int            cur_tag = 10;
  logic          exp_wr = 1'b0;
  logic [AW-1:0] exp_addr = '0;
  logic [DW-1:0] exp_data = '0;
  logic [DW-1:0] ref_mem[int];

  function automatic logic [7:0] ref_rd(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : pattern(a);
  endfunction

  task automatic push(input logic [5:0] v, input int tg, input int n);
    for (int i = 0; i < n; i++) begin exp_q.push_back(v); tag_q.push_back(tg); end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      cur_v = V_IDLE; cur_tag = 10;
    end else begin
      if (!cur_v[5] && req) begin
        exp_wr = req_wr; exp_addr = req_addr; exp_data = req_wdata;
        if (req_wr) begin
          ref_mem[int'(req_addr)] = req_wdata;
          push(6'b111100, 2, SETUP_N);
          push(6'b100110, 2, PULSE_N);
          push(6'b101100, 3, 1);
          push(6'b111101, 6, 1);
          push(6'b111100, 4, WGAP_N - 1);
        end else begin
          push(6'b111100, 5, SETUP_N);
          push(6'b101000, 5, RACC_N);
          push(6'b111101, 6, 1);
          push(6'b111100, 7, TURN_N - 1);
        end
      end
      if (exp_q.size() > 0) begin
        cur_v = exp_q.pop_front(); cur_tag = tag_q.pop_front();
      end else begin
        cur_v = V_IDLE; cur_tag = 10;
      end
    end
  end

  // memory model state
  logic [DW-1:0] mem_arr[int];
  bit            in_wr = 0, mdrv = 0, prev_ce_n = 1;
  int            wp_cnt = 0, ds_cnt = 0, rd_cnt = 0, rel_cnt = 0;
  logic [DW-1:0] last_dq = '0;
  logic [AW-1:0] ce_addr = '0;

  function automatic logic [7:0] mem_rd(input int a);
    return mem_arr.exists(a) ? mem_arr[a] : pattern(a);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      // per-cycle comparison against the schedule
      chk({busy, ce_n, we_n, oe_n, dq_oe, done} == cur_v, tagname(cur_tag),
          "strobes", int'({busy, ce_n, we_n, oe_n, dq_oe, done}), int'(cur_v));
      if (cur_v[5]) chk(maddr == exp_addr, "R9", "addr", int'(maddr), int'(exp_addr));
      if (cur_v[1]) chk(dq_o == exp_data, "R2", "wdata", int'(dq_o), int'(exp_data));
      if (cur_v[0] && !exp_wr)
        chk(rdata == ref_rd(int'(exp_addr)), "R6", "rdata", int'(rdata),
            int'(ref_rd(int'(exp_addr))));

      // memory timing checks
      if (!oe_n && !we_n) chk(0, "R3", "oe during write", 0, 1);
      if (dq_oe && (mdrv || rel_cnt > 0)) chk(0, "R7", "bus contention", rel_cnt, 0);
      if (!ce_n && !we_n) begin
        if (!in_wr) begin in_wr = 1; wp_cnt = 0; ds_cnt = 0; end
        wp_cnt++;
        if (dq_oe) begin
          if (ds_cnt > 0 && dq_o == last_dq) ds_cnt++; else ds_cnt = 1;
          last_dq = dq_o;
        end else ds_cnt = 0;
      end else if (in_wr) begin
        in_wr = 0;
        chk(wp_cnt >= MIN_WP, "R2", "write pulse", wp_cnt, MIN_WP);
        chk(ds_cnt >= MIN_DS, "R2", "data setup", ds_cnt, MIN_DS);
        chk(we_n && !ce_n, "R3", "write ended by we", int'({ce_n, we_n}), 1);
        mem_arr[int'(maddr)] = last_dq;
      end
      if (!ce_n) begin
        if (prev_ce_n) ce_addr = maddr;
        else if (maddr != ce_addr) chk(0, "R9", "addr moved", int'(maddr), int'(ce_addr));
      end
      prev_ce_n = ce_n;
      if (!ce_n && !oe_n && we_n) begin
        rd_cnt++;
        mdrv = 1;
        dq_i = (rd_cnt >= MIN_ACC) ? mem_rd(int'(maddr)) : ~mem_rd(int'(maddr));
      end else begin
        if (mdrv) begin mdrv = 0; rel_cnt = REL_N; end
        else if (rel_cnt > 0) rel_cnt--;
        if (rel_cnt == 0) dq_i = '0;
        rd_cnt = 0;
      end
    end
  end

  task automatic op(input bit wr, input int a, input int d);
    @(negedge clk);
    req = 1'b1; req_wr = wr; req_addr = AW'(a); req_wdata = DW'(d);
    @(negedge clk);
    req = 1'b0;
    while (cur_v[5]) @(negedge clk);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog R10 act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, dq_oe} == 3'b000 && {ce_n, we_n, oe_n} == 3'b111, "R1",
        "reset outputs", int'({busy, done, dq_oe, ce_n, we_n, oe_n}), 8'h07);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && ce_n && we_n && oe_n && !dq_oe, "R1", "after reset",
        int'({busy, ce_n, we_n, oe_n, dq_oe}), 5'b01110);

    op(1, 0, 8'h5A);                  // R2 R3 R4
    op(0, 0, 0);                      // R5 R6
    op(1, 13'h1FFF, 8'hFF);           // top address
    op(1, 13'h1FFE, 8'h00);
    op(0, 13'h1FFF, 0);
    op(0, 13'h1FFE, 0);
    op(0, 13'h0777, 0);               // unwritten location

    // R8 R7: request held high during a read, new command must wait
    @(negedge clk);
    req = 1'b1; req_wr = 1'b0; req_addr = 13'h0100;
    @(negedge clk);
    req_wr = 1'b1; req_addr = 13'h0ABC; req_wdata = 8'h3C;
    while (cur_v[5]) @(negedge clk);
    @(negedge clk);
    req = 1'b0;
    while (cur_v[5]) @(negedge clk);
    op(0, 13'h0ABC, 0);

    for (int i = 0; i < 6; i++) op(1, i * 1000 + 5, i * 29 + 1);
    for (int i = 0; i < 6; i++) op(0, i * 1000 + 5, 0);
    op(0, 13'h0100, 0);
    repeat (4) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule